// File: doc/BRIEF.md
# Accumulator ALU with Selective Status Flags

This block is the byte-wide execution stage of a small accumulator-style microcontroller. Each cycle it combines the working register W with a second operand: either a byte read from the file register or an immediate literal. It returns the result byte and a strobe saying where that byte must be written. The write goes to W or back to the file register, as chosen by the destination bit for register-form operations.

It also returns the next carry, digit-carry and zero flags. Each operation updates only its own subset of those flags and passes the rest through unchanged from a small flag register. The flag register loads the next values only on an enable pulse.

Increment/decrement-with-skip and the two bit tests raise a skip request for the program sequencer instead of changing flags. Register reads, writes, opcode decoding and branching stay outside the block.

Top module: `acc_alu`

## Requirements
- R1: Register-form operations (add, subtract, AND, OR, XOR, complement, increment, decrement, both skip variants, move-file, rotates, swap) assert the W strobe when the destination bit is 0 and the file strobe when it is 1. Literal operations and clear-W write only W. Move-W-to-file, clear-file, bit-set and bit-clear write only the file. No-op and both bit tests write nothing. The two strobes are never high together.
- R2: Add (W plus file, W plus literal) gives the sum modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is 1 exactly when the result is zero.
- R3: The register subtract gives file minus W, and the literal subtract gives literal minus W. C is 1 when no borrow leaves bit 7, DC is 1 when no borrow leaves bit 3, and Z marks a zero result.
- R4: AND, OR and XOR (both forms), complement, increment, decrement, move-file, clear-file and clear-W set Z when the result is zero. C and DC keep the registered values. Clears give 0 with Z = 1, and move-file returns the file byte unchanged.
- R5: Rotate-left yields {f[6:0], carry_in} and sets C to f[7]. Rotate-right yields {carry_in, f[7:1]} and sets C to f[0]. DC and Z keep the registered values.
- R6: Nibble swap (result {f[3:0], f[7:4]}), move-W-to-file (result W), load-literal (result literal), no-op, bit set/clear and both skip variants leave all three next flags equal to the registered flags.
- R7: Increment-and-skip returns f+1 and decrement-and-skip returns f-1, modulo 256. Skip is high exactly when that result is zero.
- R8: Bit-set and bit-clear return f with only bit bit_i (0..7) forced to 1 or 0. Test-clear skips when f[bit_i] is 0, and test-set skips when f[bit_i] is 1.
- R9: Skip is low for every operation not named in R7 and R8, and for opcode values 28 to 31, which act as no-ops.
- R10: After reset the flag register reads C = DC = Z = 0. In a cycle with en_i high it loads the next flags at the clock edge, and otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Commit the next flags at this edge |
| op_i | input | 5 | Operation select (package enumeration, 0 to 27) |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | File register operand |
| lit_i | input | 8 | Immediate literal |
| bit_i | input | 3 | Bit index for bit operations |
| dst_i | input | 1 | Destination: 0 to W, 1 to file |
| c_i | input | 1 | Carry fed into rotates |
| res_o | output | 8 | Result byte |
| wr_w_o | output | 1 | Write result to W |
| wr_f_o | output | 1 | Write result to file register |
| c_nx_o | output | 1 | Next carry |
| dc_nx_o | output | 1 | Next digit carry |
| z_nx_o | output | 1 | Next zero flag |
| skip_o | output | 1 | Skip the next instruction |
| c_q_o | output | 1 | Registered carry |
| dc_q_o | output | 1 | Registered digit carry |
| z_q_o | output | 1 | Registered zero flag |

## Verification
Register add and literal subtract are swept over every W and operand pair. This separates carry from digit carry and borrow from no-borrow, and it reaches all the zero-result cases. Skip variants run over all 256 file values, and bit tests over every index crossed with every byte, so an off-by-one index or an inverted test polarity shows up. Every opcode also sees pseudo-random operands, destination bits, carry inputs and preloaded flags, so a flag leaking into an operation that must hold it is caught. Periodic enable pulses with changing inputs check that the flag register loads and holds.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD_F    = 5'd0,
        OP_AND_F    = 5'd1,
        OP_CLR_F    = 5'd2,
        OP_CLR_W    = 5'd3,
        OP_NOT_F    = 5'd4,
        OP_DEC_F    = 5'd5,
        OP_DEC_SKZ  = 5'd6,
        OP_INC_F    = 5'd7,
        OP_INC_SKZ  = 5'd8,
        OP_OR_F     = 5'd9,
        OP_MOV_F    = 5'd10,
        OP_MOV_WF   = 5'd11,
        OP_NOP      = 5'd12,
        OP_ROL_F    = 5'd13,
        OP_ROR_F    = 5'd14,
        OP_SUB_F    = 5'd15,
        OP_SWAP_F   = 5'd16,
        OP_XOR_F    = 5'd17,
        OP_BIT_CLR  = 5'd18,
        OP_BIT_SET  = 5'd19,
        OP_TEST_CLR = 5'd20,
        OP_TEST_SET = 5'd21,
        OP_ADD_L    = 5'd22,
        OP_AND_L    = 5'd23,
        OP_OR_L     = 5'd24,
        OP_MOV_L    = 5'd25,
        OP_SUB_L    = 5'd26,
        OP_XOR_L    = 5'd27
    } alu_op_e;

    localparam int OP_COUNT = 28;

    typedef enum logic [3:0] {
        LF_AND, LF_OR, LF_XOR, LF_NOT, LF_INC, LF_DEC,
        LF_SWAP, LF_ROL, LF_ROR, LF_PASS
    } lfn_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_o,
    output logic              dc_o
);
    localparam int NIB = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [NIB:0]      low;
    logic [DATA_W:0]   full;

    // Subtraction is a + ~b + 1, so carry out means "no borrow".
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub_i};
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        sum_o = full[DATA_W-1:0];
        c_o   = full[DATA_W];
        dc_o  = low[NIB];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lfn_e              fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] y_o,
    output logic              cout_o
);
    localparam int NIB = DATA_W / 2;

    always_comb begin
        y_o    = a_i;
        cout_o = cin_i;
        unique case (fn_i)
            LF_AND:  y_o = a_i & b_i;
            LF_OR:   y_o = a_i | b_i;
            LF_XOR:  y_o = a_i ^ b_i;
            LF_NOT:  y_o = ~a_i;
            LF_INC:  y_o = a_i + DATA_W'(1);
            LF_DEC:  y_o = a_i - DATA_W'(1);
            LF_SWAP: y_o = {a_i[NIB-1:0], a_i[DATA_W-1:NIB]};
            LF_ROL: begin
                y_o    = {a_i[DATA_W-2:0], cin_i};
                cout_o = a_i[DATA_W-1];
            end
            LF_ROR: begin
                y_o    = {cin_i, a_i[DATA_W-1:1]};
                cout_o = a_i[0];
            end
            default: y_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_bitop.sv
module acc_alu_bitop #(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [BIT_W-1:0]  idx_i,
    output logic [DATA_W-1:0] set_o,
    output logic [DATA_W-1:0] clr_o,
    output logic              tbit_o
);
    logic [DATA_W-1:0] sel;

    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        assign sel[i] = (idx_i == BIT_W'(i));
    end

    assign set_o  = val_i | sel;
    assign clr_o  = val_i & ~sel;
    assign tbit_o = |(val_i & sel);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] f_i,
    input  logic [DATA_W-1:0] lit_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              dst_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_w_o,
    output logic              wr_f_o,
    output logic              c_nx_o,
    output logic              dc_nx_o,
    output logic              z_nx_o,
    output logic              skip_o,
    output logic              c_q_o,
    output logic              dc_q_o,
    output logic              z_q_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr_w;
        logic              wr_f;
        flags_t            flg;
        logic              skip;
    } nx_t;

    alu_op_e           op;
    logic              is_lit;
    logic              as_sub;
    logic [DATA_W-1:0] src, as_a, as_b, as_sum, lg_y;
    logic [DATA_W-1:0] b_set, b_clr;
    logic              as_c, as_dc, lg_c, b_tst;
    lfn_e              lfn;
    nx_t               nx;
    flags_t            flags_d, flags_q;

    // Operand steering, kept apart from the result mux.
    always_comb begin
        op     = alu_op_e'(op_i);
        is_lit = op inside {OP_ADD_L, OP_AND_L, OP_OR_L, OP_SUB_L, OP_XOR_L, OP_MOV_L};
        src    = is_lit ? lit_i : f_i;
        as_sub = op inside {OP_SUB_F, OP_SUB_L};
        as_a   = as_sub ? src : w_i;
        as_b   = as_sub ? w_i : src;
        case (op)
            OP_AND_F, OP_AND_L:   lfn = LF_AND;
            OP_OR_F,  OP_OR_L:    lfn = LF_OR;
            OP_XOR_F, OP_XOR_L:   lfn = LF_XOR;
            OP_NOT_F:             lfn = LF_NOT;
            OP_INC_F, OP_INC_SKZ: lfn = LF_INC;
            OP_DEC_F, OP_DEC_SKZ: lfn = LF_DEC;
            OP_SWAP_F:            lfn = LF_SWAP;
            OP_ROL_F:             lfn = LF_ROL;
            OP_ROR_F:             lfn = LF_ROR;
            default:              lfn = LF_PASS;
        endcase
    end

    acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i(as_a), .b_i(as_b), .sub_i(as_sub),
        .sum_o(as_sum), .c_o(as_c), .dc_o(as_dc)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .fn_i(lfn), .a_i(src), .b_i(w_i), .cin_i(c_i),
        .y_o(lg_y), .cout_o(lg_c)
    );

    acc_alu_bitop #(.DATA_W(DATA_W)) u_bitop (
        .val_i(f_i), .idx_i(bit_i),
        .set_o(b_set), .clr_o(b_clr), .tbit_o(b_tst)
    );

    // Next-value computation.
    always_comb begin
        nx      = '0;
        nx.flg  = flags_q;
        case (op)
            OP_ADD_F, OP_SUB_F: begin
                nx.res  = as_sum;
                nx.wr_w = !dst_i;
                nx.wr_f = dst_i;
                nx.flg  = '{c: as_c, dc: as_dc, z: (as_sum == '0)};
            end
            OP_ADD_L, OP_SUB_L: begin
                nx.res  = as_sum;
                nx.wr_w = 1'b1;
                nx.flg  = '{c: as_c, dc: as_dc, z: (as_sum == '0)};
            end
            OP_AND_F, OP_OR_F, OP_XOR_F, OP_NOT_F, OP_INC_F, OP_DEC_F, OP_MOV_F: begin
                nx.res   = lg_y;
                nx.wr_w  = !dst_i;
                nx.wr_f  = dst_i;
                nx.flg.z = (lg_y == '0);
            end
            OP_AND_L, OP_OR_L, OP_XOR_L: begin
                nx.res   = lg_y;
                nx.wr_w  = 1'b1;
                nx.flg.z = (lg_y == '0);
            end
            OP_CLR_F: begin
                nx.wr_f  = 1'b1;
                nx.flg.z = 1'b1;
            end
            OP_CLR_W: begin
                nx.wr_w  = 1'b1;
                nx.flg.z = 1'b1;
            end
            OP_INC_SKZ, OP_DEC_SKZ: begin
                nx.res  = lg_y;
                nx.wr_w = !dst_i;
                nx.wr_f = dst_i;
                nx.skip = (lg_y == '0);
            end
            OP_ROL_F, OP_ROR_F: begin
                nx.res   = lg_y;
                nx.wr_w  = !dst_i;
                nx.wr_f  = dst_i;
                nx.flg.c = lg_c;
            end
            OP_SWAP_F: begin
                nx.res  = lg_y;
                nx.wr_w = !dst_i;
                nx.wr_f = dst_i;
            end
            OP_MOV_WF: begin
                nx.res  = w_i;
                nx.wr_f = 1'b1;
            end
            OP_MOV_L: begin
                nx.res  = lit_i;
                nx.wr_w = 1'b1;
            end
            OP_BIT_SET: begin
                nx.res  = b_set;
                nx.wr_f = 1'b1;
            end
            OP_BIT_CLR: begin
                nx.res  = b_clr;
                nx.wr_f = 1'b1;
            end
            OP_TEST_CLR: nx.skip = !b_tst;
            OP_TEST_SET: nx.skip = b_tst;
            default: ;
        endcase
        flags_d = en_i ? nx.flg : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign res_o   = nx.res;
    assign wr_w_o  = nx.wr_w;
    assign wr_f_o  = nx.wr_f;
    assign c_nx_o  = nx.flg.c;
    assign dc_nx_o = nx.flg.dc;
    assign z_nx_o  = nx.flg.z;
    assign skip_o  = nx.skip;
    assign c_q_o   = flags_q.c;
    assign dc_q_o  = flags_q.dc;
    assign z_q_o   = flags_q.z;

    // R1: never both destinations in one operation
    a_r1_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_w_o && wr_f_o));

    // R2: adder output matches a plain widened sum of W and the operand
    a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_ADD_F, OP_ADD_L}) |->
        (({1'b0, w_i} + {1'b0, src}) == {c_nx_o, res_o}));

    // R5: rotates leave DC and Z alone
    a_r5_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_ROL_F, OP_ROR_F}) |->
        (dc_nx_o == flags_q.dc && z_nx_o == flags_q.z));

    // R6: flag-neutral operations
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_SWAP_F, OP_MOV_WF, OP_MOV_L, OP_NOP, OP_BIT_SET, OP_BIT_CLR,
                    OP_INC_SKZ, OP_DEC_SKZ, OP_TEST_CLR, OP_TEST_SET}) |->
        ({c_nx_o, dc_nx_o, z_nx_o} == flags_q));

    // R9: skip only from the skip-capable operations
    a_r9_skip_src: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (op inside {OP_INC_SKZ, OP_DEC_SKZ, OP_TEST_CLR, OP_TEST_SET}));

    // R10: load on enable, hold otherwise
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ({c_q_o, dc_q_o, z_q_o} == $past({c_nx_o, dc_nx_o, z_nx_o})));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable({c_q_o, dc_q_o, z_q_o}));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    import acc_alu_pkg::*;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] w = '0, f = '0, lit = '0;
    logic [2:0] bidx = '0;
    logic       dst = 1'b0, cin = 1'b0;
    logic [7:0] res;
    logic       wr_w, wr_f, c_nx, dc_nx, z_nx, skip, c_q, dc_q, z_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [2:0] exp_q = 3'b000;   // {c, dc, z}
    int unsigned seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .op_i(op), .w_i(w), .f_i(f),
        .lit_i(lit), .bit_i(bidx), .dst_i(dst), .c_i(cin), .res_o(res),
        .wr_w_o(wr_w), .wr_f_o(wr_f), .c_nx_o(c_nx), .dc_nx_o(dc_nx),
        .z_nx_o(z_nx), .skip_o(skip), .c_q_o(c_q), .dc_q_o(dc_q), .z_q_o(z_q)
    );

    typedef struct {
        int res;
        bit ww, wf, sk;
        logic [2:0] flg;
        string req;
    } exp_t;

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic exp_t model(int o, int wv, int fv, int lv, int b, bit d, bit ci,
                                   logic [2:0] q);
        exp_t e;
        int s;
        bit zf;
        e.res = 0; e.ww = 0; e.wf = 0; e.sk = 0; e.flg = q; e.req = "R9";
        case (o)
            OP_ADD_F, OP_ADD_L: begin
                s = (o == OP_ADD_L) ? lv : fv;
                e.res = (wv + s) % 256;
                zf = (e.res == 0);
                e.flg = {bit'((wv + s) > 255), bit'(((wv % 16) + (s % 16)) > 15), zf};
                e.req = "R2";
            end
            OP_SUB_F, OP_SUB_L: begin
                s = (o == OP_SUB_L) ? lv : fv;
                e.res = (s - wv + 256) % 256;
                zf = (e.res == 0);
                e.flg = {bit'(s >= wv), bit'((s % 16) >= (wv % 16)), zf};
                e.req = "R3";
            end
            OP_AND_F, OP_AND_L, OP_OR_F, OP_OR_L, OP_XOR_F, OP_XOR_L,
            OP_NOT_F, OP_INC_F, OP_DEC_F, OP_MOV_F, OP_CLR_F, OP_CLR_W: begin
                s = (o inside {OP_AND_L, OP_OR_L, OP_XOR_L}) ? lv : fv;
                case (o)
                    OP_AND_F, OP_AND_L: e.res = wv & s;
                    OP_OR_F, OP_OR_L:   e.res = wv | s;
                    OP_XOR_F, OP_XOR_L: e.res = wv ^ s;
                    OP_NOT_F:           e.res = 255 - fv;
                    OP_INC_F:           e.res = (fv + 1) % 256;
                    OP_DEC_F:           e.res = (fv + 255) % 256;
                    OP_MOV_F:           e.res = fv;
                    default:            e.res = 0;
                endcase
                e.flg[0] = (e.res == 0);
                e.req = "R4";
            end
            OP_ROL_F: begin
                e.res = ((fv * 2) % 256) + ci;
                e.flg[2] = bit'(fv / 128);
                e.req = "R5";
            end
            OP_ROR_F: begin
                e.res = (fv / 2) + ci * 128;
                e.flg[2] = bit'(fv % 2);
                e.req = "R5";
            end
            OP_SWAP_F: begin e.res = (fv % 16) * 16 + fv / 16; e.req = "R6"; end
            OP_MOV_WF: begin e.res = wv; e.req = "R6"; end
            OP_MOV_L:  begin e.res = lv; e.req = "R6"; end
            OP_INC_SKZ: begin e.res = (fv + 1) % 256; e.sk = (e.res == 0); e.req = "R7"; end
            OP_DEC_SKZ: begin e.res = (fv + 255) % 256; e.sk = (e.res == 0); e.req = "R7"; end
            OP_BIT_SET: begin e.res = fv | (1 << b); e.req = "R8"; end
            OP_BIT_CLR: begin e.res = fv & ~(1 << b) & 255; e.req = "R8"; end
            OP_TEST_CLR: begin e.sk = ((fv >> b) % 2) == 0; e.req = "R8"; end
            OP_TEST_SET: begin e.sk = ((fv >> b) % 2) == 1; e.req = "R8"; end
            default: e.req = "R9";
        endcase
        // destinations (R1)
        if (o inside {OP_ADD_L, OP_SUB_L, OP_AND_L, OP_OR_L, OP_XOR_L, OP_MOV_L, OP_CLR_W})
            e.ww = 1;
        else if (o inside {OP_MOV_WF, OP_CLR_F, OP_BIT_SET, OP_BIT_CLR})
            e.wf = 1;
        else if (o inside {OP_ADD_F, OP_SUB_F, OP_AND_F, OP_OR_F, OP_XOR_F, OP_NOT_F,
                           OP_INC_F, OP_DEC_F, OP_INC_SKZ, OP_DEC_SKZ, OP_MOV_F,
                           OP_ROL_F, OP_ROR_F, OP_SWAP_F}) begin
            e.ww = !d;
            e.wf = d;
        end
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h (op=%0d w=%0h f=%0h lit=%0h b=%0d d=%0b c=%0b)",
                     req, what, got, exp, op, w, f, lit, bidx, dst, cin);
        end
    endtask

    task automatic drive(int o, int wv, int fv, int lv, int b, bit d, bit ci);
        op = 5'(o); w = 8'(wv); f = 8'(fv); lit = 8'(lv); bidx = 3'(b); dst = d; cin = ci;
    endtask

    task automatic check_now();
        exp_t e;
        e = model(int'(op), int'(w), int'(f), int'(lit), int'(bidx), dst, cin, exp_q);
        chk({wr_w, wr_f} == {e.ww, e.wf}, "R1", "strobes", {wr_w, wr_f}, {e.ww, e.wf});
        if (e.ww || e.wf)
            chk(int'(res) == e.res, e.req, "result", int'(res), e.res);
        chk({c_nx, dc_nx, z_nx} == e.flg, e.req, "flags", {c_nx, dc_nx, z_nx}, e.flg);
        chk(skip == e.sk, (e.sk || e.req == "R7" || e.req == "R8") ? e.req : "R9",
            "skip", skip, e.sk);
    endtask

    task automatic apply(int o, int wv, int fv, int lv, int b, bit d, bit ci);
        drive(o, wv, fv, lv, b, d, ci);
        #1;
        check_now();
    endtask

    // R10: commit flags with an enable pulse, then confirm hold
    task automatic commit(int o, int wv, int fv, int lv, int b, bit d, bit ci);
        exp_t e;
        @(negedge clk);
        drive(o, wv, fv, lv, b, d, ci);
        en = 1'b1;
        #1;
        check_now();
        e = model(o, wv, fv, lv, b, d, ci, exp_q);
        @(posedge clk);
        #1;
        en = 1'b0;
        exp_q = e.flg;
        chk({c_q, dc_q, z_q} == exp_q, "R10", "flag load", {c_q, dc_q, z_q}, exp_q);
        drive(OP_ADD_F, 8'hff, 8'h01, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        chk({c_q, dc_q, z_q} == exp_q, "R10", "flag hold", {c_q, dc_q, z_q}, exp_q);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 3);
        @(negedge clk);
        chk({c_q, dc_q, z_q} == 3'b000, "R10", "reset flags", {c_q, dc_q, z_q}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({c_q, dc_q, z_q} == 3'b000, "R10", "post-reset flags", {c_q, dc_q, z_q}, 0);

        // preload all flags to 1 (R2 corner: 0xff + 0x01)
        commit(OP_ADD_F, 8'hff, 8'h01, 0, 0, 0, 0);

        // R2 exhaustive register add
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(OP_ADD_F, a, b, 0, 0, bit'(b % 2), 0);

        // R3 exhaustive literal subtract (literal minus W)
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(OP_SUB_L, a, 8'h5a, b, 0, 0, 0);

        // R7 skip variants over every file value
        for (int v = 0; v < 256; v++) begin
            apply(OP_INC_SKZ, 0, v, 0, 0, bit'(v % 2), 0);
            apply(OP_DEC_SKZ, 0, v, 0, 0, bit'(v / 128), 0);
        end

        // R8 every bit index against every byte
        for (int b = 0; b < 8; b++)
            for (int v = 0; v < 256; v++) begin
                apply(OP_TEST_CLR, 0, v, 0, b, 0, 0);
                apply(OP_TEST_SET, 0, v, 0, b, 0, 0);
                apply(OP_BIT_SET, 0, v, 0, b, 0, 0);
                apply(OP_BIT_CLR, 0, v, 0, b, 0, 0);
            end

        // every opcode (R1..R9, including undefined codes for R9) with random data
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 400; i++) begin
                int unsigned r;
                r = rnd();
                if (i % 50 == 0)
                    commit(int'(r % OP_COUNT), int'(rnd() % 256), int'(rnd() % 256),
                           int'(rnd() % 256), 0, 0, bit'(r / 7 % 2));
                else
                    apply(o, int'(r % 256), int'((r >> 8) % 256), int'((r >> 16) % 256),
                          int'((r >> 24) % 8), bit'((r >> 27) % 2), bit'((r >> 28) % 2));
            end

        // R4/R3 zero corner, R5 rotate carry-in corners
        apply(OP_SUB_F, 8'h37, 8'h37, 0, 0, 1, 0);
        apply(OP_CLR_W, 8'h99, 8'h99, 0, 0, 0, 0);
        apply(OP_ROL_F, 0, 8'h80, 0, 0, 0, 1);
        apply(OP_ROR_F, 0, 8'h01, 0, 0, 1, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule